// File: doc/BRIEF.md
# Block Address Translation Array

This block maps 32-bit effective addresses to physical addresses through a small, fully associative array of block translations. Each of the four entries describes one aligned, power-of-two region between 128 KB and 256 MB. The region is given by an effective base, a size mask and a physical base. Software loads the entries one at a time through a register-write port. A lookup is combinational against the stored entries, so the hit flag, winning entry and physical address come back in the same cycle as the effective address.

A translation-enable input turns the array into an identity path. When it is low, the physical address equals the effective address, and the lookup reports a bypass rather than a miss. A chip instantiates the block twice, once on the instruction-fetch path and once on the data path. Protection, cache attributes and exception signalling belong to the surrounding logic.

Top module: `blk_xlate_array`

## Requirements
- R1: After reset every entry is invalid, so every lookup with translation enabled misses.
- R2: With `xlate_en` low, `bypass` is 1, `hit` is 0, `hit_idx` is 0 and `pa` equals `ea`, whatever the entries hold.
- R3: An entry matches when it is valid and two conditions hold. First, `ea[31:28]` equals base bits [14:11]. Second, every bit of `ea[27:17]` whose mask bit is 0 equals the base bit in the same place, where base bit k lines up with `ea[17+k]`.
- R4: On a hit, `pa[16:0]` equals `ea[16:0]`. Each bit of `pa[31:17]` comes from `ea` where the mask bit (extended with four zeros on the high side) is 1, and from the physical base where it is 0.
- R5: A mask of 0 gives a 128 KB block, in which all of `ea[31:17]` must equal the effective base.
- R6: A mask of all ones (0x7FF) gives a 256 MB block, in which only `ea[31:28]` is compared and `pa[27:0]` equals `ea[27:0]`.
- R7: When several valid entries match, the lowest-numbered one wins, and `hit_idx` reports its index.
- R8: A write changes lookups starting in the cycle after the write. A lookup in the cycle of the write still sees the old contents.
- R9: With translation enabled and no entry matching, `hit` is 0, `bypass` is 0, `hit_idx` is 0 and `pa` is 0.
- R10: Writing an entry with `wr_valid` 0 removes it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 2 | Entry to write |
| wr_eblk | input | 15 | Effective base, lines up with ea[31:17] |
| wr_mask | input | 11 | Size mask over ea[27:17], contiguous ones from bit 0 |
| wr_pblk | input | 15 | Physical base, lines up with pa[31:17] |
| wr_valid | input | 1 | Valid bit of the written entry |
| xlate_en | input | 1 | Translation enable; low selects identity |
| ea | input | 32 | Effective address to look up |
| hit | output | 1 | An entry matched |
| bypass | output | 1 | Translation disabled |
| hit_idx | output | 2 | Winning entry, 0 when there is no hit |
| pa | output | 32 | Physical address |

## Verification
Lookups are aimed at each end of the block-size range. A 128 KB entry separates an exact base compare from a loose one. A 256 MB entry shows that offset bits pass through and only the top nibble is compared, and a 1 MB entry exercises a partial mask. Entries that cover the same addresses check the priority order, and an invalidation then shows that the next entry takes over. Lookups placed in the cycle of a write tell the old contents from the new. A long run of addresses drawn near the programmed bases compares every cycle against a model that computes block size arithmetically. With the enable low, that run tells a bypass apart from a miss.

// File: rtl/blk_xlate_array.sv
module blk_xlate_array #(
  parameter int N   = 4,
  parameter int AW  = 32,
  parameter int OFS = 17,
  parameter int MW  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [AW-OFS-1:0]    wr_eblk,
  input  logic [MW-1:0]        wr_mask,
  input  logic [AW-OFS-1:0]    wr_pblk,
  input  logic                 wr_valid,
  input  logic                 xlate_en,
  input  logic [AW-1:0]        ea,
  output logic                 hit,
  output logic                 bypass,
  output logic [$clog2(N)-1:0] hit_idx,
  output logic [AW-1:0]        pa
);
  localparam int BW = AW - OFS;
  localparam int IW = $clog2(N);

  logic [N-1:0]  vld;
  logic [BW-1:0] eblk [N];
  logic [BW-1:0] keep [N];
  logic [BW-1:0] pblk [N];
  logic [N-1:0]  match;

  wire [BW-1:0] ea_blk = ea[AW-1:OFS];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i]  <= 1'b0;
        eblk[i] <= '0;
        keep[i] <= '0;
        pblk[i] <= '0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        vld[i]  <= wr_valid;
        eblk[i] <= wr_eblk;
        keep[i] <= BW'(wr_mask);
        pblk[i] <= wr_pblk;
      end
    end
    assign match[i] = vld[i] && (((ea_blk ^ eblk[i]) & ~keep[i]) == '0);
  end

  logic [IW-1:0] win;
  logic [BW-1:0] pa_blk;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) win = IW'(i);
  end

  assign pa_blk  = (pblk[win] & ~keep[win]) | (ea_blk & keep[win]);
  assign bypass  = !xlate_en;
  assign hit     = xlate_en && (match != '0);
  assign hit_idx = hit ? win : '0;
  assign pa      = !xlate_en ? ea : hit ? {pa_blk, ea[OFS-1:0]} : '0;
endmodule

module blk_xlate_array_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_idx,
  input logic [14:0] wr_eblk,
  input logic        wr_valid,
  input logic        xlate_en,
  input logic [31:0] ea,
  input logic        hit,
  input logic        bypass,
  input logic [1:0]  hit_idx,
  input logic [31:0] pa
);
  a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> (bypass && !hit && hit_idx == 2'd0 && pa == ea));
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && !hit) |-> (pa == 32'd0 && hit_idx == 2'd0 && !bypass));
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[16:0] == ea[16:0]));
  a_r3_top_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !bypass);
  a_r8_new_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_idx == 2'd0 && wr_valid) && $past(rst_n) && xlate_en &&
     ea[31:17] == $past(wr_eblk)) |-> (hit && hit_idx == 2'd0));
endmodule

bind blk_xlate_array blk_xlate_array_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_eblk(wr_eblk),
  .wr_valid(wr_valid), .xlate_en(xlate_en), .ea(ea), .hit(hit), .bypass(bypass),
  .hit_idx(hit_idx), .pa(pa)
);

// File: tb/test_blk_xlate_array.sv
module test_blk_xlate_array;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, xlate_en = 0;
  logic [1:0] wr_idx = 0;
  logic [14:0] wr_eblk = 0, wr_pblk = 0;
  logic [10:0] wr_mask = 0;
  logic [31:0] ea = 0;
  logic hit, bypass;
  logic [1:0] hit_idx;
  logic [31:0] pa;

  int checks = 0, fails = 0;
  bit done = 0;

  bit          m_v [4];
  longint      m_ebase [4];
  longint      m_pbase [4];
  longint      m_size [4];

  always #2 clk = ~clk;

  blk_xlate_array i_blk_xlate_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_eblk(wr_eblk),
    .wr_mask(wr_mask), .wr_pblk(wr_pblk), .wr_valid(wr_valid), .xlate_en(xlate_en),
    .ea(ea), .hit(hit), .bypass(bypass), .hit_idx(hit_idx), .pa(pa)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_v[i] = 0;
    end else if (wr_en) begin
      m_v[wr_idx]     = wr_valid;
      m_size[wr_idx]  = longint'(1) << (17 + $countones(wr_mask));
      m_ebase[wr_idx] = longint'(wr_eblk) * 131072;
      m_pbase[wr_idx] = longint'(wr_pblk) * 131072;
    end
  end

  task automatic compare(string req);
    logic e_hit, e_byp;
    logic [1:0] e_idx;
    logic [31:0] e_pa;
    longint a;
    a = longint'(ea);
    e_hit = 0; e_byp = 0; e_idx = 0; e_pa = 0;
    if (!xlate_en) begin
      e_byp = 1; e_pa = ea;
    end else begin
      for (int i = 3; i >= 0; i--)
        if (m_v[i] && (a / m_size[i]) == (m_ebase[i] / m_size[i])) begin
          e_hit = 1; e_idx = 2'(i);
          e_pa = 32'((m_pbase[i] / m_size[i]) * m_size[i] + a % m_size[i]);
        end
    end
    checks++;
    if (hit !== e_hit || bypass !== e_byp || hit_idx !== e_idx || pa !== e_pa) begin
      fails++;
      $display("FAIL %s ea=%h got hit=%b byp=%b idx=%0d pa=%h exp hit=%b byp=%b idx=%0d pa=%h",
               req, ea, hit, bypass, hit_idx, pa, e_hit, e_byp, e_idx, e_pa);
    end
  endtask

  task automatic step(input bit en, input logic [31:0] a, string req,
                      input bit w = 0, input logic [1:0] wi = 0,
                      input logic [14:0] we = 0, input logic [10:0] wm = 0,
                      input logic [14:0] wp = 0, input bit wv = 0);
    @(posedge clk); #1;
    xlate_en = en; ea = a;
    wr_en = w; wr_idx = wi; wr_eblk = we; wr_mask = wm; wr_pblk = wp; wr_valid = wv;
    #2 compare(req);
  endtask

  task automatic wr(input logic [1:0] wi, input logic [14:0] we, input logic [10:0] wm,
                    input logic [14:0] wp, input bit wv);
    step(1, 32'h0, "R8", 1, wi, we, wm, wp, wv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(1, 32'h0002_1234, "R1");
    step(1, 32'hFFFF_FFFC, "R1");
    step(0, 32'h0002_1234, "R2");
    // R8: lookup in the write cycle sees the old (empty) entry
    step(1, 32'h0002_0044, "R8", 1, 2'd0, 15'h0001, 11'h000, 15'h4000, 1);
    step(1, 32'h0002_0044, "R8");
    step(1, 32'h0003_FFFF, "R5");
    step(1, 32'h0004_0000, "R5");
    wr(2'd1, 15'h1800, 11'h7FF, 15'h4000, 1);
    step(1, 32'h3ABC_DEF0, "R6");
    step(1, 32'h4ABC_DEF0, "R3");
    wr(2'd2, 15'h2008, 11'h007, 15'h6010, 1);
    step(1, 32'h4015_5555, "R4");
    step(1, 32'h4010_0001, "R4");
    step(1, 32'h4020_0000, "R9");
    wr(2'd3, 15'h0000, 11'h7FF, 15'h7800, 1);
    step(1, 32'h0002_0010, "R7");
    step(1, 32'h0102_0010, "R7");
    wr(2'd0, 15'h0001, 11'h000, 15'h4000, 0);
    step(1, 32'h0002_0010, "R10");
    step(0, 32'h3000_0000, "R2");
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      case (k % 4)
        0: r[31:28] = 4'h0;
        1: r[31:28] = 4'h3;
        2: r[31:20] = 12'h401;
        default: ;
      endcase
      step((k % 7) != 0, r, "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule